// File: doc/BRIEF.md
# Parallel Flash Programming Host Sequencer

This block sits on the host side of a byte-wide asynchronous flash bus. It runs three operations: byte program, whole-chip erase and reading the identifier bytes. User logic starts an operation with a single-cycle request that carries an operation code, a target address and a data byte. The block then drives chip enable, output enable, write enable, the address and the data bus itself. All bus timing comes from parameterised counts of system-clock cycles, so one netlist can serve different clock rates.

Each operation begins with the two-write unlock prefix that the flash expects. A program or erase then waits for the device to finish by reading one fixed address over and over. The operation is over when bit 6 of the data holds the same value on two reads in a row. A bounded read count turns a device that never settles into an error. After a program settles, the block reads the byte back and compares it with the requested value. The identifier operation collects two bytes and then leaves identifier mode with a single write. The bus data pins are split into an output, an output enable and an input, so the block itself contains no tri-state logic.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, chip enable, output enable and write enable are all high, the host data driver is off, and busy and done are low.
- R2: Every write strobe holds write enable low for exactly WP_CYC clock cycles. Write enable stays high for at least WPH_CYC cycles between strobes. Address and write data do not change while the strobe is low, and the host drives the data bus during the whole strobe.
- R3: Output enable is high for at least OEH_CYC cycles before every read strobe and is low for exactly RD_CYC cycles. The host data driver is off before output enable falls and stays off while it is low. The read byte is captured in the last low cycle.
- R4: A program (op code 0) issues exactly four writes, in this order: 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then the user byte to the target address.
- R5: An erase (op code 1) issues exactly six writes, in this order: 0xAA and 0x55 (to 0x5555 and 0x2AAA), 0x80 to 0x5555, 0xAA and 0x55 again, then 0x10 to 0x5555.
- R6: An identifier read (op code 2) issues the unlock prefix and 0x90 to 0x5555. It then reads address 0 into result0 and address 1 into result1, and finally writes 0xF0 to 0x5555. That is four writes and two reads in total.
- R7: A program or erase polls by reading repeatedly, at the target address for a program and at address 0 for an erase. Polling ends at the first read whose bit 6 equals bit 6 of the read just before it.
- R8: If POLL_LIMIT poll reads pass without that match, the operation ends with err high and no further read.
- R9: After a program's poll ends, the block reads the target address once more and puts the byte on result0. err is high when that byte differs from the requested byte.
- R10: A request is accepted only when busy is low and the op code is not 3. busy goes high in the cycle after acceptance. done is a single-cycle pulse, and busy falls after it. Requests made while busy are ignored. Chip enable is low exactly while busy is high.
- R11: Write enable and output enable are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request, one cycle |
| req_op | input | 2 | 0 program, 1 erase, 2 identifier read, 3 not accepted |
| req_addr | input | 16 | Target address for a program |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the operation ends |
| err | output | 1 | Poll timeout or readback mismatch; valid with done |
| result0 | output | 8 | Readback byte (program) or identifier byte 0 |
| result1 | output | 8 | Identifier byte 1 |
| fl_addr | output | 16 | Flash address bus |
| fl_dq_o | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Host data driver enable |
| fl_dq_i | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
Some properties are checked on every cycle. Address and write data must hold still under a write strobe. The host driver must have been released before output enable falls. The two strobes must never overlap. A request made while busy must leave the latched operation untouched. done must not last longer than one cycle. The poll counter must not pass its limit, and a mismatching readback must always raise err. Other behaviour can only be shown by the bench's scenarios against a behavioural flash model, with strobe widths and gaps measured at the pins. These are the command order (the model acts only on correct sequences), the exact number of poll reads for each busy length and data bit 6, the timeout, a failed readback, erase having an effect, and the identifier bytes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int FA_W = 16;
  localparam int FD_W = 8;

  localparam logic [FA_W-1:0] UNLOCK_HI = 16'h5555;
  localparam logic [FA_W-1:0] UNLOCK_LO = 16'h2AAA;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_IDENT = 2'd2
  } op_e;

  typedef struct packed {
    logic            is_read;
    logic            last;
    logic [FA_W-1:0] a;
    logic [FD_W-1:0] d;
  } step_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // True when the toggling status bit has stopped changing.
  function automatic logic bit6_settled(input logic [FD_W-1:0] prev, input logic [FD_W-1:0] cur);
    return prev[6] == cur[6];
  endfunction

  // Bus step number idx of an operation.
  function automatic step_t cmd_step(input op_e op, input logic [2:0] idx,
                                     input logic [FA_W-1:0] ta, input logic [FD_W-1:0] td);
    step_t s;
    s = '0;
    if (idx == 3'd0 || idx == 3'd3) begin
      s.a = UNLOCK_HI;
      s.d = 8'hAA;
    end else if (idx == 3'd1 || idx == 3'd4) begin
      s.a = UNLOCK_LO;
      s.d = 8'h55;
    end
    case (op)
      OP_PROG: begin
        if (idx == 3'd2) begin
          s.a = UNLOCK_HI;
          s.d = 8'hA0;
        end else if (idx == 3'd3) begin
          s.a    = ta;
          s.d    = td;
          s.last = 1'b1;
        end
      end
      OP_ERASE: begin
        if (idx == 3'd2) begin
          s.a = UNLOCK_HI;
          s.d = 8'h80;
        end else if (idx == 3'd5) begin
          s.a    = UNLOCK_HI;
          s.d    = 8'h10;
          s.last = 1'b1;
        end
      end
      default: begin
        if (idx == 3'd2) begin
          s.a = UNLOCK_HI;
          s.d = 8'h90;
        end else if (idx == 3'd3 || idx == 3'd4) begin
          s.is_read = 1'b1;
          s.a       = {{(FA_W-1){1'b0}}, idx[0] ^ 1'b1};
          s.d       = '0;
        end else if (idx == 3'd5) begin
          s.a    = UNLOCK_HI;
          s.d    = 8'hF0;
          s.last = 1'b1;
        end
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/flash_bus_engine.sv
module flash_bus_engine
  import flash_seq_pkg::*;
#(
  parameter int WP_CYC  = 9,
  parameter int WPH_CYC = 9,
  parameter int OEH_CYC = 15,
  parameter int RD_CYC  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_wr,
  input  logic            start_rd,
  input  logic [FA_W-1:0] addr,
  input  logic [FD_W-1:0] wdata,
  output logic            op_done,
  output logic [FD_W-1:0] rdata,
  output logic [FA_W-1:0] addr_o,
  output logic [FD_W-1:0] dq_o,
  output logic            dq_oe,
  input  logic [FD_W-1:0] dq_i,
  output logic            oe_n,
  output logic            we_n
);

  localparam int CMAX = max4(WP_CYC, WPH_CYC, OEH_CYC, RD_CYC);
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] WP_LAST  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] WPH_LAST = CW'(WPH_CYC - 1);
  localparam logic [CW-1:0] OEH_LAST = CW'(OEH_CYC - 1);
  localparam logic [CW-1:0] RD_LAST  = CW'(RD_CYC - 1);

  typedef enum logic [2:0] {E_IDLE, E_WSET, E_WLOW, E_WHIGH, E_RGAP, E_RLOW} ph_e;

  ph_e             ph;
  logic [CW-1:0]   cnt;
  logic [FA_W-1:0] a_q;
  logic [FD_W-1:0] d_q;

  // Named bus events for the properties below.
  logic write_strobe, read_strobe, host_drive, engine_idle;
  assign write_strobe = (ph == E_WLOW);
  assign read_strobe  = (ph == E_RLOW);
  assign host_drive   = (ph == E_WSET) || (ph == E_WLOW) || (ph == E_WHIGH);
  assign engine_idle  = (ph == E_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= E_IDLE;
      cnt     <= '0;
      a_q     <= '0;
      d_q     <= '0;
      rdata   <= '0;
      op_done <= 1'b0;
    end else begin
      op_done <= 1'b0;
      case (ph)
        E_IDLE: begin
          cnt <= '0;
          if (start_wr) begin
            a_q <= addr;
            d_q <= wdata;
            ph  <= E_WSET;
          end else if (start_rd) begin
            a_q <= addr;
            ph  <= E_RGAP;
          end
        end
        E_WSET: ph <= E_WLOW;
        E_WLOW: begin
          if (cnt == WP_LAST) begin
            cnt <= '0;
            ph  <= E_WHIGH;
          end else cnt <= cnt + 1'b1;
        end
        E_WHIGH: begin
          if (cnt == WPH_LAST) begin
            cnt     <= '0;
            ph      <= E_IDLE;
            op_done <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        E_RGAP: begin
          if (cnt == OEH_LAST) begin
            cnt <= '0;
            ph  <= E_RLOW;
          end else cnt <= cnt + 1'b1;
        end
        E_RLOW: begin
          if (cnt == RD_LAST) begin
            cnt     <= '0;
            rdata   <= dq_i;
            op_done <= 1'b1;
            ph      <= E_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: ph <= E_IDLE;
      endcase
    end
  end

  assign we_n   = ~write_strobe;
  assign oe_n   = ~read_strobe;
  assign dq_oe  = host_drive;
  assign addr_o = a_q;
  assign dq_o   = d_q;

  assert_we_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> ($stable(addr_o) && $stable(dq_o) && dq_oe));

  assert_dq_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> $past(!dq_oe));

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr || start_rd) |-> engine_idle);

endmodule

// File: rtl/flash_toggle_poll.sv
module flash_toggle_poll
  import flash_seq_pkg::*;
#(
  parameter int POLL_LIMIT = 4096
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            smp_vld,
  input  logic [FD_W-1:0] smp,
  output logic            settled,
  output logic            expired
);

  localparam int PW = $clog2(POLL_LIMIT + 1);

  logic            have_prev;
  logic [FD_W-1:0] prev;
  logic [PW-1:0]   cnt;

  assign settled = smp_vld && have_prev && bit6_settled(prev, smp);
  assign expired = smp_vld && !settled && ((int'(cnt) + 1) >= POLL_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev      <= '0;
      cnt       <= '0;
    end else if (clr) begin
      have_prev <= 1'b0;
      prev      <= '0;
      cnt       <= '0;
    end else if (smp_vld) begin
      have_prev <= 1'b1;
      prev      <= smp;
      if (int'(cnt) < POLL_LIMIT) cnt <= cnt + 1'b1;
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= POLL_LIMIT);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int WP_CYC     = 9,
  parameter int WPH_CYC    = 9,
  parameter int OEH_CYC    = 15,
  parameter int RD_CYC     = 6,
  parameter int POLL_LIMIT = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_data,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [7:0]  result0,
  output logic [7:0]  result1,
  output logic [15:0] fl_addr,
  output logic [7:0]  fl_dq_o,
  output logic        fl_dq_oe,
  input  logic [7:0]  fl_dq_i,
  output logic        fl_ce_n,
  output logic        fl_oe_n,
  output logic        fl_we_n
);

  typedef enum logic [2:0] {T_IDLE, T_CMD, T_POLL, T_VERIFY, T_FIN} st_e;

  st_e             state;
  op_e             op_q;
  logic [FA_W-1:0] addr_q;
  logic [FD_W-1:0] data_q;
  logic [2:0]      step_q;
  logic            wait_q;
  logic            err_q;
  logic [FD_W-1:0] res0_q, res1_q;

  logic            accept;
  step_t           cur;
  logic            launch_wr, launch_rd;
  logic [FA_W-1:0] launch_a;
  logic [FD_W-1:0] launch_d;
  logic            eng_done;
  logic [FD_W-1:0] eng_rdata;
  logic            poll_smp, poll_ok, poll_late;
  logic            readback_bad;

  assign accept       = (state == T_IDLE) && req_valid && (req_op != 2'd3);
  assign cur          = cmd_step(op_q, step_q, addr_q, data_q);
  assign poll_smp     = (state == T_POLL) && eng_done;
  assign readback_bad = (state == T_VERIFY) && eng_done && (eng_rdata != data_q);

  always_comb begin
    launch_wr = 1'b0;
    launch_rd = 1'b0;
    launch_a  = '0;
    launch_d  = '0;
    if (!wait_q) begin
      case (state)
        T_CMD: begin
          launch_wr = !cur.is_read;
          launch_rd = cur.is_read;
          launch_a  = cur.a;
          launch_d  = cur.d;
        end
        T_POLL: begin
          launch_rd = 1'b1;
          launch_a  = (op_q == OP_PROG) ? addr_q : '0;
        end
        T_VERIFY: begin
          launch_rd = 1'b1;
          launch_a  = addr_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= T_IDLE;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      step_q <= '0;
      wait_q <= 1'b0;
      err_q  <= 1'b0;
      res0_q <= '0;
      res1_q <= '0;
    end else begin
      if (launch_wr || launch_rd) wait_q <= 1'b1;
      else if (eng_done)          wait_q <= 1'b0;
      case (state)
        T_IDLE: begin
          if (accept) begin
            op_q   <= op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
            step_q <= '0;
            err_q  <= 1'b0;
            state  <= T_CMD;
          end
        end
        T_CMD: begin
          if (eng_done) begin
            if (cur.is_read) begin
              if (step_q == 3'd3) res0_q <= eng_rdata;
              else                res1_q <= eng_rdata;
            end
            if (cur.last) state <= (op_q == OP_IDENT) ? T_FIN : T_POLL;
            else          step_q <= step_q + 3'd1;
          end
        end
        T_POLL: begin
          if (poll_ok) state <= (op_q == OP_PROG) ? T_VERIFY : T_FIN;
          else if (poll_late) begin
            err_q <= 1'b1;
            state <= T_FIN;
          end
        end
        T_VERIFY: begin
          if (eng_done) begin
            res0_q <= eng_rdata;
            err_q  <= readback_bad;
            state  <= T_FIN;
          end
        end
        T_FIN:   state <= T_IDLE;
        default: state <= T_IDLE;
      endcase
    end
  end

  flash_bus_engine #(
    .WP_CYC (WP_CYC),
    .WPH_CYC(WPH_CYC),
    .OEH_CYC(OEH_CYC),
    .RD_CYC (RD_CYC)
  ) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_wr(launch_wr),
    .start_rd(launch_rd),
    .addr    (launch_a),
    .wdata   (launch_d),
    .op_done (eng_done),
    .rdata   (eng_rdata),
    .addr_o  (fl_addr),
    .dq_o    (fl_dq_o),
    .dq_oe   (fl_dq_oe),
    .dq_i    (fl_dq_i),
    .oe_n    (fl_oe_n),
    .we_n    (fl_we_n)
  );

  flash_toggle_poll #(
    .POLL_LIMIT(POLL_LIMIT)
  ) u_poll (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept),
    .smp_vld(poll_smp),
    .smp    (eng_rdata),
    .settled(poll_ok),
    .expired(poll_late)
  );

  assign busy    = (state != T_IDLE);
  assign done    = (state == T_FIN);
  assign err     = err_q;
  assign result0 = res0_q;
  assign result1 = res1_q;
  assign fl_ce_n = ~busy;

  assert_req_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> ($stable(addr_q) && $stable(data_q) && $stable(op_q)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_readback_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    readback_bad |=> (err_q && done));

endmodule

// File: tb/sim_flash_prog_seq.sv
module sim_flash_prog_seq;

  localparam int CLK_P = 10;
  localparam int WP    = 9;
  localparam int WPH   = 9;
  localparam int OEH   = 15;
  localparam int RDC   = 6;
  localparam int LIM   = 8;
  localparam logic [7:0] ID_A = 8'hC2;
  localparam logic [7:0] ID_B = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        busy, done, err;
  logic [7:0]  result0, result1;
  logic [15:0] fl_addr;
  logic [7:0]  fl_dq_o, fl_dq_i;
  logic        fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

  always #(CLK_P/2) clk = ~clk;

  flash_prog_seq #(.WP_CYC(WP), .WPH_CYC(WPH), .OEH_CYC(OEH), .RD_CYC(RDC), .POLL_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .busy(busy), .done(done), .err(err), .result0(result0),
    .result1(result1), .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
    .fl_dq_i(fl_dq_i), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n));

  // ---------------- behavioural flash model ----------------
  logic [7:0]  mem [256];
  logic [15:0] lat_a;
  logic [7:0]  rd_q = 8'hFF;
  int          cst = 0;
  bit          id_mode = 0;
  int          busy_left = 0;
  bit          tog = 0;
  int          prog_n = 0, erase_n = 0;
  logic [7:0]  stuck = 8'h00;
  int          rd_cnt = 0, wr_cnt = 0;

  assign fl_dq_i = fl_oe_n ? 8'hFF : rd_q;

  always @(negedge fl_we_n) if (rst_n) begin
    lat_a = fl_addr;
    wr_cnt++;
  end

  always @(posedge fl_we_n) if (rst_n) begin
    case (cst)
      0: if (lat_a == 16'h5555 && fl_dq_o == 8'hAA) cst = 1;
         else if (fl_dq_o == 8'hF0) id_mode = 0;
      1: cst = (lat_a == 16'h2AAA && fl_dq_o == 8'h55) ? 2 : 0;
      2: begin
        cst = 0;
        if (lat_a == 16'h5555) begin
          if (fl_dq_o == 8'hA0) cst = 3;
          else if (fl_dq_o == 8'h80) cst = 4;
          else if (fl_dq_o == 8'h90) id_mode = 1;
          else if (fl_dq_o == 8'hF0) id_mode = 0;
        end
      end
      3: begin
        mem[lat_a[7:0]] = (mem[lat_a[7:0]] & fl_dq_o) | stuck;
        busy_left = prog_n; tog = 0; cst = 0;
      end
      4: cst = (lat_a == 16'h5555 && fl_dq_o == 8'hAA) ? 5 : 0;
      5: cst = (lat_a == 16'h2AAA && fl_dq_o == 8'h55) ? 6 : 0;
      6: begin
        cst = 0;
        if (lat_a == 16'h5555 && fl_dq_o == 8'h10) begin
          for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
          busy_left = erase_n; tog = 0;
        end
      end
      default: cst = 0;
    endcase
  end

  always @(negedge fl_oe_n) if (rst_n) begin
    rd_cnt++;
    if (busy_left > 0) begin
      busy_left--;
      tog = ~tog;
      rd_q = (mem[fl_addr[7:0]] & 8'hBF) | {1'b0, tog, 6'b0};
    end else if (id_mode) rd_q = fl_addr[0] ? ID_B : ID_A;
    else rd_q = mem[fl_addr[7:0]];
  end

  // ---------------- pin timing monitor ----------------
  int  tviol = 0;
  int  we_lo = 0, we_hi = 1000, oe_lo = 0, oe_hi = 1000;
  bit  prev_we = 1, prev_oe = 1;

  always @(negedge clk) if (rst_n) begin
    if (!fl_we_n) begin
      if (prev_we && we_hi < WPH) tviol++;
      if (!fl_dq_oe || fl_ce_n) tviol++;
      we_lo = prev_we ? 1 : we_lo + 1;
      we_hi = 0;
    end else begin
      if (!prev_we && we_lo != WP) tviol++;
      we_hi++;
    end
    if (!fl_oe_n) begin
      if (prev_oe && oe_hi < OEH) tviol++;
      if (fl_dq_oe || !fl_we_n) tviol++;
      oe_lo = prev_oe ? 1 : oe_lo + 1;
      oe_hi = 0;
    end else begin
      if (!prev_oe && oe_lo != RDC) tviol++;
      oe_hi++;
    end
    if (fl_ce_n != !busy) tviol++;
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
  end

  // ---------------- checking ----------------
  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int poll_reads(input int n, input bit d6);
    int r;
    if (n == 0) r = 2;
    else r = (d6 == n[0]) ? n + 1 : n + 2;
    return (r > LIM) ? LIM : r;
  endfunction

  function automatic bit poll_timeout(input int n, input bit d6);
    int r;
    if (n == 0) r = 2;
    else r = (d6 == n[0]) ? n + 1 : n + 2;
    return r > LIM;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                        input bit poke);
    int guard;
    rd_cnt = 0; wr_cnt = 0; tviol = 0;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
    chk("R10 busy after accept", int'(busy), 1);
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (poke && guard == 20) begin
        req_valid = 1; req_op = 2'd1; req_addr = 16'h00FF; req_data = 8'h00;
      end else req_valid = 0;
    end
    chk("R10 done reached", int'(done), 1);
    @(negedge clk);
    chk("R10 done single cycle and busy released", int'(done) + 2 * int'(busy), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] er0;
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ce_n", int'(fl_ce_n), 1);
    chk("R1 oe_n", int'(fl_oe_n), 1);
    chk("R1 we_n", int'(fl_we_n), 1);
    chk("R1 dq_oe", int'(fl_dq_oe), 0);
    chk("R1 busy/done", int'(busy) + int'(done), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4 R7 R9 R2 R3: program sweep over busy length and data bit 6
    for (int n = 0; n < 6; n++) begin
      for (int j = 0; j < 2; j++) begin
        d = {1'b0, j[0], 6'(n * 5 + 3)};
        prog_n = n;
        run_op(2'd0, 16'h0020 + 16'(n * 2 + j), d, 0);
        chk("R4 program write count", wr_cnt, 4);
        chk("R7 poll reads + R9 verify read", rd_cnt, poll_reads(n, d[6]) + 1);
        chk("R9 readback value", int'(result0), int'(d));
        chk("R9 no error", int'(err), 0);
        chk("R2 R3 R11 pin timing", tviol, 0);
      end
    end

    // R10 request during busy ignored, op 3 not accepted
    prog_n = 1;
    run_op(2'd0, 16'h0040, 8'h33, 1);
    chk("R10 poked program writes", wr_cnt, 4);
    chk("R10 poked program result", int'(result0), 8'h33);
    chk("R10 poked program err", int'(err), 0);
    @(negedge clk);
    req_valid = 1; req_op = 2'd3;
    @(negedge clk);
    req_valid = 0;
    chk("R10 op 3 not accepted", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R10 op 3 no bus activity", int'(fl_ce_n), 1);

    // R8 timeout
    prog_n = 50;
    run_op(2'd0, 16'h0050, 8'h0F, 0);
    chk("R8 timeout error", int'(err), 1);
    chk("R8 reads stop at limit", rd_cnt, LIM);
    chk("R8 timing", tviol, 0);
    busy_left = 0;

    // R9 readback mismatch via stuck bit
    prog_n = 0; stuck = 8'h01;
    run_op(2'd0, 16'h0060, 8'h20, 0);
    chk("R9 mismatch error", int'(err), 1);
    chk("R9 mismatch result", int'(result0), 8'h21);
    chk("R9 mismatch reads", rd_cnt, poll_reads(0, 1'b0) + 1);
    stuck = 8'h00;

    // R9 cannot raise bits before erase
    er0 = {1'b0, 1'b0, 6'd3};
    run_op(2'd0, 16'h0020, 8'hFF, 0);
    chk("R9 no raise without erase", int'(result0), int'(er0));
    chk("R9 no raise err", int'(err), 1);

    // R5 R7 erase sweep
    for (int n = 0; n < 4; n++) begin
      erase_n = n;
      run_op(2'd1, 16'h0000, 8'h00, 0);
      chk("R5 erase write count", wr_cnt, 6);
      chk("R7 erase poll reads", rd_cnt, poll_reads(n, 1'b1));
      chk("R7 erase err", int'(err), int'(poll_timeout(n, 1'b1)));
      chk("R5 timing", tviol, 0);
    end
    prog_n = 0;
    run_op(2'd0, 16'h0020, 8'hFF, 0);
    chk("R5 erased byte reads FF", int'(result0), 8'hFF);
    chk("R5 erased byte err", int'(err), 0);

    // R6 identifier read, then normal access again
    run_op(2'd2, 16'h0000, 8'h00, 0);
    chk("R6 id byte 0", int'(result0), int'(ID_A));
    chk("R6 id byte 1", int'(result1), int'(ID_B));
    chk("R6 id writes", wr_cnt, 4);
    chk("R6 id reads", rd_cnt, 2);
    chk("R6 id err", int'(err), 0);
    chk("R6 timing", tviol, 0);
    run_op(2'd0, 16'h0070, 8'h5C, 0);
    chk("R6 exit restores array reads", int'(result0), 8'h5C);
    chk("R6 exit err", int'(err), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule